// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the transmit and receive error counters of a CAN node and derives the node's fault-confinement state from them. The CAN bit engine, which is outside this block, decides when a counter moves. It signals each change with increment pulses that carry a step size, or with single-step decrement pulses. The block then reports the counters, the warning, error-passive and bus-off flags, and a two-bit state code. All of these are packed into one 32-bit status word.

When the transmit counter would pass its maximum, the node goes bus-off. At that point the block raises a single request to abort every pending transmit slot. It leaves bus-off only after software has held and then released reset mode, and after the bus has then shown 128 idle runs of 11 consecutive recessive bits. The bit engine marks each bit time with a strobe that carries the sampled level. When the wait completes, both counters return to zero, the node becomes error-active, and a state-change event fires.

Every bus error that the bit engine reports is captured into an 8-bit code that gives its type, direction and frame segment. The code is output one cycle later as an event record, together with a snapshot of both counters.

Top module: `can_fault_tracker`

## Requirements
- R1: `status_word` carries the receive count in bits 7:0, the transmit count in bits 15:8, the warning flag in bit 17, the error-passive flag in bit 18 and the bus-off flag in bit 19. All other bits read zero, and the whole word is zero after reset.
- R2: The warning flag is set exactly when either counter is 96 or more.
- R3: The error-passive flag is set exactly when either counter is 128 or more.
- R4: `node_state` reports the first condition that holds, in this order: bus-off (3), error-passive (2), warning (1), error-active (0). `state_evt` is high for exactly the one cycle after any edge that changes `node_state`.
- R5: An increment pulse adds its 4-bit step to its counter. The receive counter saturates at 255, and a decrement stops at 0. When an increment and a decrement arrive together for the same counter, only the increment takes effect.
- R6: If a transmit increment would take the counter above 255, the node enters bus-off and the transmit count holds at 255. `tx_abort_req` pulses for one cycle at that entry. While the node is bus-off, all counter pulses are ignored.
- R7: Recessive bit strobes do not advance recovery until reset mode has been asserted during bus-off and then released. Strobes seen while reset mode is high also do not count.
- R8: After that release, the node completes 128 runs of 11 consecutive recessive strobes. On the edge of the strobe that completes the last run, bus-off clears, both counters become 0 and `state_evt` fires.
- R9: A dominant strobe during the recovery wait discards the current partial run but keeps the count of runs already completed.
- R10: A `berr_valid` pulse produces `berr_evt` one cycle later. `berr_code` then holds the segment in bits 4:0, the direction in bit 5 (1 = receiving) and the type in bits 7:6 (00 bit, 01 form, 10 stuff, 11 other). `berr_counters` holds {transmit, receive} as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_mode | input | 1 | Controller held in reset mode by software |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| bit_recessive | input | 1 | Sampled bus level at the strobe, 1 = recessive |
| tec_inc | input | 1 | Transmit counter increment pulse |
| tec_inc_amt | input | 4 | Step added by `tec_inc` |
| tec_dec | input | 1 | Transmit counter decrement-by-one pulse |
| rec_inc | input | 1 | Receive counter increment pulse |
| rec_inc_amt | input | 4 | Step added by `rec_inc` |
| rec_dec | input | 1 | Receive counter decrement-by-one pulse |
| berr_valid | input | 1 | Bus error reported this cycle |
| berr_type | input | 2 | Error type of the reported bus error |
| berr_rx | input | 1 | 1 if the error happened while receiving |
| berr_seg | input | 5 | Frame segment in which the error happened |
| status_word | output | 32 | Packed counters and state flags |
| node_state | output | 2 | Reported fault-confinement state |
| state_evt | output | 1 | One-cycle pulse on a state change |
| tx_abort_req | output | 1 | One-cycle request to abort all pending transmit slots |
| berr_evt | output | 1 | Bus error record valid |
| berr_code | output | 8 | Captured error code |
| berr_counters | output | 16 | Counter snapshot {transmit, receive} |

## Verification
The bench walks the receive counter one step at a time from 0 to saturation and back to 0. This catches any off-by-one at the 96 and 128 limits, any wrap at 255 or below 0, and any missing or doubled state event. The transmit counter is stepped in eights until it overflows. That checks that bus-off takes priority over the flags that are also set, and that the abort request is a single pulse. During recovery the bench first feeds recessive strobes without a reset-mode cycle, and then breaks a run with a dominant bit after two runs are complete. A design that counts too early, or that clears completed runs, would then leave bus-off one strobe early or late. All 256 combinations of error type, direction and segment are captured. A swapped field would show up in the code.

// File: rtl/can_ft_pkg.sv
package can_ft_pkg;

  localparam int CNT_W  = 8;
  localparam int STEP_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } node_state_e;

  // Counter plus step, one bit wider so that overflow is visible.
  function automatic logic [CNT_W:0] wide_add(cnt_t a, logic [STEP_W-1:0] step);
    return {1'b0, a} + {{(CNT_W + 1 - STEP_W){1'b0}}, step};
  endfunction

  function automatic cnt_t sat_add(cnt_t a, logic [STEP_W-1:0] step);
    logic [CNT_W:0] w;
    w = wide_add(a, step);
    return w[CNT_W] ? {CNT_W{1'b1}} : w[CNT_W-1:0];
  endfunction

  function automatic cnt_t floor_dec(cnt_t a);
    return (a == '0) ? a : a - 1'b1;
  endfunction

  function automatic logic at_least(cnt_t a, int unsigned lim);
    return 32'(a) >= lim;
  endfunction

  function automatic node_state_e pick_state(logic bo, logic ep, logic wn);
    if (bo)      return ST_BUSOFF;
    else if (ep) return ST_PASSIVE;
    else if (wn) return ST_WARN;
    else         return ST_ACTIVE;
  endfunction

  function automatic logic [7:0] pack_code(logic [1:0] kind, logic rx, logic [4:0] seg);
    return {kind, rx, seg};
  endfunction

  function automatic logic [31:0] pack_status(cnt_t tec, cnt_t rec, logic bo, logic ep, logic wn);
    return {12'b0, bo, ep, wn, 1'b0, tec, rec};
  endfunction

endpackage

// File: rtl/can_ft_counters.sv
module can_ft_counters
  import can_ft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tec_inc,
  input  logic [STEP_W-1:0] tec_inc_amt,
  input  logic              tec_dec,
  input  logic              rec_inc,
  input  logic [STEP_W-1:0] rec_inc_amt,
  input  logic              rec_dec,
  input  logic              recov_done,
  output cnt_t              tec,
  output cnt_t              rec,
  output logic              bus_off,
  output logic              abort_pulse
);

  logic [CNT_W:0] tec_sum;
  logic           tec_ovf;
  logic           bus_off_d;

  assign tec_sum = wide_add(tec, tec_inc_amt);
  assign tec_ovf = tec_inc && tec_sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec       <= '0;
      rec       <= '0;
      bus_off   <= 1'b0;
      bus_off_d <= 1'b0;
    end else begin
      bus_off_d <= bus_off;
      if (recov_done) begin
        tec     <= '0;
        rec     <= '0;
        bus_off <= 1'b0;
      end else if (!bus_off) begin
        if (tec_ovf) begin
          tec     <= {CNT_W{1'b1}};
          bus_off <= 1'b1;
        end else if (tec_inc) begin
          tec <= tec_sum[CNT_W-1:0];
        end else if (tec_dec) begin
          tec <= floor_dec(tec);
        end
        if (rec_inc)      rec <= sat_add(rec, rec_inc_amt);
        else if (rec_dec) rec <= floor_dec(rec);
      end
    end
  end

  assign abort_pulse = bus_off & ~bus_off_d;

  a_r6_busoff_tec_max: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> tec == {CNT_W{1'b1}});

  a_r6_busoff_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !recov_done) |=> $stable(rec));

  a_r5_rec_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_dec && !rec_inc && rec == '0 && !recov_done) |=> rec == '0);

  a_r5_rec_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_inc && !bus_off && rec == {CNT_W{1'b1}}) |=> rec == {CNT_W{1'b1}});

endmodule

// File: rtl/can_ft_recovery.sv
module can_ft_recovery #(
  parameter int unsigned IDLE_BITS = 11,
  parameter int unsigned IDLE_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_off,
  input  logic reset_mode,
  input  logic bit_tick,
  input  logic bit_recessive,
  output logic recov_done
);

  localparam int RUN_W  = $clog2(IDLE_BITS + 1);
  localparam int IDLE_W = $clog2(IDLE_RUNS + 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(IDLE_BITS - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_RUNS - 1);

  logic              armed;
  logic [RUN_W-1:0]  run_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              counting;
  logic              run_end;

  assign counting   = bus_off && armed && !reset_mode && bit_tick;
  assign run_end    = counting && bit_recessive && (run_cnt == RUN_LAST);
  assign recov_done = run_end && (idle_cnt == IDLE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      run_cnt  <= '0;
      idle_cnt <= '0;
    end else if (!bus_off) begin
      armed    <= 1'b0;
      run_cnt  <= '0;
      idle_cnt <= '0;
    end else begin
      if (reset_mode) armed <= 1'b1;
      if (counting) begin
        if (!bit_recessive) begin
          run_cnt <= '0;
        end else if (run_end) begin
          run_cnt  <= '0;
          idle_cnt <= recov_done ? '0 : idle_cnt + 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end

  a_r9_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !bit_recessive) |=> run_cnt == '0);

  a_r9_runs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !bit_recessive) |=> $stable(idle_cnt));

  a_r7_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && reset_mode) |=> $stable(idle_cnt));

  a_r7_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !armed && !reset_mode) |=> idle_cnt == '0);

endmodule

// File: rtl/can_ft_errcap.sv
module can_ft_errcap
  import can_ft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       berr_valid,
  input  logic [1:0] berr_type,
  input  logic       berr_rx,
  input  logic [4:0] berr_seg,
  input  cnt_t       tec,
  input  cnt_t       rec,
  output logic       berr_evt,
  output logic [7:0] berr_code,
  output logic [15:0] berr_counters
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      berr_evt      <= 1'b0;
      berr_code     <= '0;
      berr_counters <= '0;
    end else begin
      berr_evt <= berr_valid;
      if (berr_valid) begin
        berr_code     <= pack_code(berr_type, berr_rx, berr_seg);
        berr_counters <= {tec, rec};
      end
    end
  end

  a_r10_record_follows: assert property (@(posedge clk) disable iff (!rst_n)
    berr_valid |=> berr_evt);

  a_r10_type_field: assert property (@(posedge clk) disable iff (!rst_n)
    berr_valid |=> berr_code[7:6] == $past(berr_type));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_valid |=> $stable(berr_code));

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
  import can_ft_pkg::*;
#(
  parameter int unsigned WARN_LIM  = 96,
  parameter int unsigned PASS_LIM  = 128,
  parameter int unsigned IDLE_BITS = 11,
  parameter int unsigned IDLE_RUNS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_mode,
  input  logic        bit_tick,
  input  logic        bit_recessive,
  input  logic        tec_inc,
  input  logic [3:0]  tec_inc_amt,
  input  logic        tec_dec,
  input  logic        rec_inc,
  input  logic [3:0]  rec_inc_amt,
  input  logic        rec_dec,
  input  logic        berr_valid,
  input  logic [1:0]  berr_type,
  input  logic        berr_rx,
  input  logic [4:0]  berr_seg,
  output logic [31:0] status_word,
  output logic [1:0]  node_state,
  output logic        state_evt,
  output logic        tx_abort_req,
  output logic        berr_evt,
  output logic [7:0]  berr_code,
  output logic [15:0] berr_counters
);

  cnt_t        tec;
  cnt_t        rec;
  logic        bus_off;
  logic        recov_done;
  logic        warn_flag;
  logic        pass_flag;
  node_state_e cur_state;
  node_state_e prev_state;

  can_ft_counters u_counters (
    .clk         (clk),
    .rst_n       (rst_n),
    .tec_inc     (tec_inc),
    .tec_inc_amt (tec_inc_amt),
    .tec_dec     (tec_dec),
    .rec_inc     (rec_inc),
    .rec_inc_amt (rec_inc_amt),
    .rec_dec     (rec_dec),
    .recov_done  (recov_done),
    .tec         (tec),
    .rec         (rec),
    .bus_off     (bus_off),
    .abort_pulse (tx_abort_req)
  );

  can_ft_recovery #(
    .IDLE_BITS (IDLE_BITS),
    .IDLE_RUNS (IDLE_RUNS)
  ) u_recovery (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_off       (bus_off),
    .reset_mode    (reset_mode),
    .bit_tick      (bit_tick),
    .bit_recessive (bit_recessive),
    .recov_done    (recov_done)
  );

  can_ft_errcap u_errcap (
    .clk           (clk),
    .rst_n         (rst_n),
    .berr_valid    (berr_valid),
    .berr_type     (berr_type),
    .berr_rx       (berr_rx),
    .berr_seg      (berr_seg),
    .tec           (tec),
    .rec           (rec),
    .berr_evt      (berr_evt),
    .berr_code     (berr_code),
    .berr_counters (berr_counters)
  );

  assign warn_flag   = at_least(tec, WARN_LIM) || at_least(rec, WARN_LIM);
  assign pass_flag   = at_least(tec, PASS_LIM) || at_least(rec, PASS_LIM);
  assign cur_state   = pick_state(bus_off, pass_flag, warn_flag);
  assign status_word = pack_status(tec, rec, bus_off, pass_flag, warn_flag);
  assign node_state  = cur_state;
  assign state_evt   = (cur_state != prev_state);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_state <= ST_ACTIVE;
    else        prev_state <= cur_state;
  end

  a_r6_abort_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[19]) |-> tx_abort_req);

  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort_req |=> !tx_abort_req);

  a_r8_return_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_word[19]) |-> (state_evt && node_state == 2'd0 && status_word[15:0] == 16'd0));

  a_r4_busoff_wins: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[19] |-> node_state == 2'd3);

  a_r4_event_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_evt && $stable(node_state)) |=> !state_evt);

endmodule

// File: tb/test_can_fault_tracker.sv
module test_can_fault_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_mode = 1'b0;
  logic        bit_tick = 1'b0;
  logic        bit_recessive = 1'b1;
  logic        tec_inc = 1'b0;
  logic [3:0]  tec_inc_amt = 4'd0;
  logic        tec_dec = 1'b0;
  logic        rec_inc = 1'b0;
  logic [3:0]  rec_inc_amt = 4'd0;
  logic        rec_dec = 1'b0;
  logic        berr_valid = 1'b0;
  logic [1:0]  berr_type = 2'd0;
  logic        berr_rx = 1'b0;
  logic [4:0]  berr_seg = 5'd0;
  logic [31:0] status_word;
  logic [1:0]  node_state;
  logic        state_evt;
  logic        tx_abort_req;
  logic        berr_evt;
  logic [7:0]  berr_code;
  logic [15:0] berr_counters;

  always #4 clk = ~clk;

  can_fault_tracker i_can_fault_tracker (
    .clk (clk), .rst_n (rst_n), .reset_mode (reset_mode),
    .bit_tick (bit_tick), .bit_recessive (bit_recessive),
    .tec_inc (tec_inc), .tec_inc_amt (tec_inc_amt), .tec_dec (tec_dec),
    .rec_inc (rec_inc), .rec_inc_amt (rec_inc_amt), .rec_dec (rec_dec),
    .berr_valid (berr_valid), .berr_type (berr_type), .berr_rx (berr_rx),
    .berr_seg (berr_seg), .status_word (status_word), .node_state (node_state),
    .state_evt (state_evt), .tx_abort_req (tx_abort_req), .berr_evt (berr_evt),
    .berr_code (berr_code), .berr_counters (berr_counters)
  );

  int n_vec = 0;
  int n_bad = 0;
  int m_tec = 0;
  int m_rec = 0;
  int m_bo  = 0;
  int m_prev_state = 0;
  int m_abort = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int exp_state();
    if (m_bo != 0) return 3;
    if (m_tec >= 128 || m_rec >= 128) return 2;
    if (m_tec >= 96 || m_rec >= 96) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] w;
    w = 32'(m_rec) | (32'(m_tec) << 8);
    if (m_tec >= 96 || m_rec >= 96) w = w | 32'h0002_0000;
    if (m_tec >= 128 || m_rec >= 128) w = w | 32'h0004_0000;
    if (m_bo != 0) w = w | 32'h0008_0000;
    return w;
  endfunction

  // Checks the status word, state code, state event and abort pulse.
  task automatic check_all(input string tag);
    int es;
    es = exp_state();
    chk(status_word == exp_status(), {tag, " R1 R2 R3 status"}, status_word, exp_status());
    chk(32'(node_state) == 32'(es), {tag, " R4 state"}, 32'(node_state), 32'(es));
    chk(state_evt == (es != m_prev_state), {tag, " R4 event"}, 32'(state_evt), 32'(es != m_prev_state));
    chk(32'(tx_abort_req) == 32'(m_abort), {tag, " R6 abort"}, 32'(tx_abort_req), 32'(m_abort));
    m_prev_state = es;
  endtask

  task automatic apply(input int ti, input int ta, input int td, input int ri, input int ra, input int rd,
                       input string tag);
    tec_inc = ti[0]; tec_inc_amt = ta[3:0]; tec_dec = td[0];
    rec_inc = ri[0]; rec_inc_amt = ra[3:0]; rec_dec = rd[0];
    @(posedge clk); #2;
    tec_inc = 1'b0; tec_dec = 1'b0; rec_inc = 1'b0; rec_dec = 1'b0;
    m_abort = 0;
    if (m_bo == 0) begin
      if (ti != 0) begin
        if (m_tec + ta > 255) begin m_tec = 255; m_bo = 1; m_abort = 1; end
        else m_tec = m_tec + ta;
      end else if (td != 0 && m_tec > 0) m_tec = m_tec - 1;
      if (ri != 0) m_rec = (m_rec + ra > 255) ? 255 : m_rec + ra;
      else if (rd != 0 && m_rec > 0) m_rec = m_rec - 1;
    end
    check_all(tag);
  endtask

  task automatic run_ticks(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; bit_recessive = lvl;
      @(posedge clk); #2;
    end
    bit_tick = 1'b0; bit_recessive = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: reset state
    chk(status_word == 32'd0, "R1 reset status", status_word, 32'd0);
    chk(node_state == 2'd0 && !state_evt && !tx_abort_req && !berr_evt, "R4 R6 R10 reset outputs",
        {28'd0, node_state, state_evt, tx_abort_req}, 32'd0);

    // R10: every type, direction and segment combination, with counters at tec 16, rec 3
    apply(1, 8, 0, 1, 3, 0, "setup");
    apply(1, 8, 0, 0, 0, 0, "setup");
    for (int c = 0; c < 256; c++) begin
      berr_valid = 1'b1; berr_type = c[7:6]; berr_rx = c[5]; berr_seg = c[4:0];
      @(posedge clk); #2;
      berr_valid = 1'b0;
      chk(berr_evt == 1'b1, "R10 record valid", 32'(berr_evt), 32'd1);
      chk(berr_code == c[7:0], "R10 code fields", 32'(berr_code), 32'(c[7:0]));
      chk(berr_counters == 16'h1003, "R10 counter snapshot", 32'(berr_counters), 32'h1003);
    end
    @(posedge clk); #2;
    chk(berr_evt == 1'b0, "R10 single record", 32'(berr_evt), 32'd0);

    // R5: increment and decrement together, increment wins
    apply(0, 0, 0, 1, 2, 1, "R5 inc+dec");
    apply(1, 1, 1, 0, 0, 0, "R5 tec inc+dec");
    // R2 R3 R5: receive sweep one step at a time to saturation
    while (m_rec < 255) apply(0, 0, 0, 1, 1, 0, "R2 R3 rec up");
    apply(0, 0, 0, 1, 15, 0, "R5 rec saturate");
    apply(0, 0, 0, 1, 15, 0, "R5 rec saturate");
    while (m_rec > 0) apply(0, 0, 0, 0, 0, 1, "R2 R3 rec down");
    apply(0, 0, 0, 0, 0, 1, "R5 rec floor");
    while (m_tec > 0) apply(0, 0, 1, 0, 0, 0, "R5 tec down");
    apply(0, 0, 1, 0, 0, 0, "R5 tec floor");

    // R2 R3 R4 R6: transmit sweep by eight up to bus-off
    apply(0, 0, 0, 1, 7, 0, "rec seed");
    while (m_bo == 0) apply(1, 8, 0, 0, 0, 0, "R4 R6 tec up");
    apply(0, 0, 0, 0, 0, 0, "R6 abort drops");
    apply(0, 0, 1, 0, 0, 1, "R6 dec ignored");
    apply(1, 4, 0, 1, 4, 0, "R6 inc ignored");

    // R7: recessive strobes before the reset-mode cycle do not count
    run_ticks(1500, 1'b1);
    check_all("R7 unarmed");
    reset_mode = 1'b1;
    run_ticks(1500, 1'b1);
    reset_mode = 1'b0;
    check_all("R7 in reset mode");

    // R9: two full runs, a broken partial run, then the rest
    run_ticks(22, 1'b1);
    run_ticks(5, 1'b1);
    run_ticks(1, 1'b0);
    run_ticks(126 * 11 - 1, 1'b1);
    check_all("R9 one strobe short");
    run_ticks(1, 1'b1);
    m_bo = 0; m_tec = 0; m_rec = 0;
    check_all("R8 recovered");
    @(posedge clk); #2;
    check_all("R8 settled");

    // R6: second entry to bus-off gives a fresh abort pulse
    while (m_bo == 0) apply(1, 15, 0, 0, 0, 0, "R6 second entry");
    chk(status_word[19] == 1'b1, "R6 bus-off again", status_word, exp_status());

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule